// File: doc/BRIEF.md
# Two-Layer Pipelined Layer Scheduler for a Layered QC-LDPC Decoder

This block is the sequencer of a row-layered QC-LDPC decoder whose check-node work is split into two stages: a global stage that forms the first and second minimum over a layer, and a local stage that forms the per-edge results and writes them back. Each cycle the scheduler addresses an external compact code table by (layer, slot). The table returns a block-column index and a circulant shift. The scheduler issues these as control for the global stage. The same fields, one layer-time later, drive the local stage.

Layers are grouped into fixed-size superlayers. Inside a superlayer the global stage works on layer u+1 while the local stage finishes layer u. At each superlayer boundary the pipeline drains for one layer-time and then refills, so with the default sizes a superlayer of 6 layers takes 7 layer-times. Slots whose table index is the padding code get no write enable in the local stage. A run starts with a `start` pulse. The run repeats the whole layer sweep for a latched number of iterations and ends with a one-cycle `done` pulse.

Top module: `ldpc_layer_sched`

## Requirements
- R1: While `rst_n` is low and after reset until the first `start`, `busy`, `done`, `g_valid`, `l_valid` and `l_wr_en` are all 0.
- R2: A layer-time is SLOTS (8) cycles. During it `g_slot` steps 0,1,...,7 and `g_layer` stays constant. `tbl_layer`/`tbl_slot` equal `g_layer`/`g_slot` in every global-valid cycle, and `g_col`/`g_shift` equal `tbl_col`/`tbl_shift` of that same cycle.
- R3: In every cycle the local fields (`l_layer`, `l_slot`, `l_col`, `l_shift`) and `l_valid` equal the global fields and `g_valid` of exactly SLOTS cycles earlier within the same run. Whenever both stages are valid, `l_layer` = `g_layer` - 1.
- R4: Layers are swept in order 0..11 in superlayers of 6. Each superlayer takes 7 layer-times. In the first layer-time only the global stage is valid. In the last (drain) layer-time only the local stage is valid. The global stage never overlaps with a local stage working on a layer of another superlayer.
- R5: `l_wr_en` is 1 exactly when `l_valid` is 1 and `l_col` is not the padding code, all ones (5'd31). `g_pad` is 1 exactly when `g_valid` is 1 and `g_col` is all ones.
- R6: `max_iter` is latched at `start`, and a value of 0 is treated as 1. A run lasts iterations × 2 × 7 × 8 cycles of `busy`. `iter_idx` counts 0,1,...; it advances only after both superlayers of an iteration have drained.
- R7: `done` is a single-cycle pulse in the cycle right after the last local slot of the final iteration. `busy` falls in that same cycle.
- R8: A `start` while busy restarts at iteration 0, layer 0, slot 0 and empties the local pipeline, so `l_valid` is 0 for the first layer-time after the restart.
- R9: Changing `max_iter` after `start` has no effect on the length of the current run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin (or restart) a decoding run |
| max_iter | input | 4 | Iteration limit, sampled at start |
| tbl_layer | output | 4 | Code table read address: layer |
| tbl_slot | output | 3 | Code table read address: slot |
| tbl_col | input | 5 | Table block-column index, all ones = padding |
| tbl_shift | input | 7 | Table circulant right-rotation amount |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| iter_idx | output | 4 | Current iteration number |
| g_valid | output | 1 | Global-stage control valid |
| g_layer | output | 4 | Global-stage layer |
| g_slot | output | 3 | Global-stage slot |
| g_col | output | 5 | Global-stage APP read block column |
| g_shift | output | 7 | Global-stage rotation amount |
| g_pad | output | 1 | Global-stage slot is padding |
| l_valid | output | 1 | Local-stage control valid |
| l_layer | output | 4 | Local-stage layer |
| l_slot | output | 3 | Local-stage slot |
| l_col | output | 5 | Local-stage write-back block column |
| l_shift | output | 7 | Local-stage rotation amount |
| l_wr_en | output | 1 | Local-stage write enable |

## Verification
The bench compares every port in every cycle of several complete runs against an arithmetic model of the sweep. It looks hardest at superlayer edges and iteration edges. A scheduler that carried overlap across a boundary would show `l_valid` in the first layer-time of superlayer 1 or of the next iteration. One that skipped the drain would end each superlayer a layer-time early. Padding slots are placed at the last slot of most layers, so a write-back not gated by the padding code raises `l_wr_en` there. The end of run is checked with zero, one and two iterations and after a restart in mid-run. These cases expose an off-by-one iteration count, a `done` that lasts more than one cycle, a limit read live instead of latched, and a restart that leaves stale local fields.

// File: rtl/lsched_pkg.sv
package lsched_pkg;

  localparam int unsigned DEF_LAYERS   = 12;
  localparam int unsigned DEF_SLOTS    = 8;
  localparam int unsigned DEF_SUPER    = 6;
  localparam int unsigned DEF_COL_W    = 5;
  localparam int unsigned DEF_Z_MAX    = 81;
  localparam int unsigned DEF_ITER_W   = 4;

  function automatic int unsigned safe_clog2(input int unsigned n);
    int unsigned w;
    w = $clog2(n);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/lsched_counters.sv
module lsched_counters
  import lsched_pkg::*;
#(
  parameter int unsigned SLOTS   = DEF_SLOTS,
  parameter int unsigned SUPER   = DEF_SUPER,
  parameter int unsigned NSUPER  = DEF_LAYERS / DEF_SUPER,
  parameter int unsigned ITER_W  = DEF_ITER_W,
  localparam int unsigned SLOT_W  = safe_clog2(SLOTS),
  localparam int unsigned PHASE_W = safe_clog2(SUPER + 1),
  localparam int unsigned SUP_W   = safe_clog2(NSUPER)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ITER_W-1:0]  max_iter,
  output logic               busy,
  output logic               done,
  output logic [SLOT_W-1:0]  slot,
  output logic [PHASE_W-1:0] phase,
  output logic [SUP_W-1:0]   sup,
  output logic [ITER_W-1:0]  iter
);

  localparam logic [SLOT_W-1:0]  SLOT_LAST  = SLOT_W'(SLOTS - 1);
  localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(SUPER);
  localparam logic [SUP_W-1:0]   SUP_LAST   = SUP_W'(NSUPER - 1);

  logic               busy_q, busy_d;
  logic               done_q, done_d;
  logic [SLOT_W-1:0]  slot_q, slot_d;
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic [SUP_W-1:0]   sup_q, sup_d;
  logic [ITER_W-1:0]  iter_q, iter_d;
  logic [ITER_W-1:0]  lim_q, lim_d;

  logic end_slot, end_phase, end_sup, end_iter;

  assign end_slot  = (slot_q == SLOT_LAST);
  assign end_phase = (phase_q == PHASE_LAST);
  assign end_sup   = (sup_q == SUP_LAST);
  assign end_iter  = (iter_q == (lim_q - ITER_W'(1)));

  always_comb begin
    busy_d  = busy_q;
    done_d  = 1'b0;
    slot_d  = slot_q;
    phase_d = phase_q;
    sup_d   = sup_q;
    iter_d  = iter_q;
    lim_d   = lim_q;
    if (start) begin
      busy_d  = 1'b1;
      slot_d  = '0;
      phase_d = '0;
      sup_d   = '0;
      iter_d  = '0;
      lim_d   = (max_iter == '0) ? ITER_W'(1) : max_iter;
    end else if (busy_q) begin
      if (!end_slot) begin
        slot_d = slot_q + SLOT_W'(1);
      end else begin
        slot_d = '0;
        if (!end_phase) begin
          phase_d = phase_q + PHASE_W'(1);
        end else begin
          phase_d = '0;
          if (!end_sup) begin
            sup_d = sup_q + SUP_W'(1);
          end else begin
            sup_d = '0;
            if (!end_iter) begin
              iter_d = iter_q + ITER_W'(1);
            end else begin
              iter_d = '0;
              busy_d = 1'b0;
              done_d = 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      slot_q  <= '0;
      phase_q <= '0;
      sup_q   <= '0;
      iter_q  <= '0;
      lim_q   <= ITER_W'(1);
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      slot_q  <= slot_d;
      phase_q <= phase_d;
      sup_q   <= sup_d;
      iter_q  <= iter_d;
      lim_q   <= lim_d;
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign slot  = slot_q;
  assign phase = phase_q;
  assign sup   = sup_q;
  assign iter  = iter_q;

  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (iter_q < lim_q)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q); // R7

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start && end_slot && !(end_phase && end_sup && end_iter))
      |=> (slot_q == '0) && busy_q); // R2

endmodule

// File: rtl/lsched_delay.sv
module lsched_delay #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);

  logic [DEPTH-1:0] vld_q;
  logic [DW-1:0]    dat_q [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      logic          v_in;
      logic [DW-1:0] d_in;
      if (i == 0) begin : g_head
        assign v_in = in_valid;
        assign d_in = in_data;
      end else begin : g_body
        assign v_in = vld_q[i-1];
        assign d_in = dat_q[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[i] <= 1'b0;
          dat_q[i] <= '0;
        end else begin
          vld_q[i] <= flush ? 1'b0 : v_in;
          dat_q[i] <= flush ? '0 : d_in;
        end
      end
    end
  endgenerate

  assign out_valid = vld_q[DEPTH-1];
  assign out_data  = dat_q[DEPTH-1];

endmodule

// File: rtl/ldpc_layer_sched.sv
module ldpc_layer_sched
  import lsched_pkg::*;
#(
  parameter int unsigned LAYERS  = DEF_LAYERS,
  parameter int unsigned SLOTS   = DEF_SLOTS,
  parameter int unsigned SUPER   = DEF_SUPER,
  parameter int unsigned COL_W   = DEF_COL_W,
  parameter int unsigned Z_MAX   = DEF_Z_MAX,
  parameter int unsigned ITER_W  = DEF_ITER_W,
  localparam int unsigned NSUPER  = LAYERS / SUPER,
  localparam int unsigned LAYER_W = safe_clog2(LAYERS),
  localparam int unsigned SLOT_W  = safe_clog2(SLOTS),
  localparam int unsigned SHIFT_W = safe_clog2(Z_MAX),
  localparam int unsigned PHASE_W = safe_clog2(SUPER + 1),
  localparam int unsigned SUP_W   = safe_clog2(NSUPER),
  localparam int unsigned FLD_W   = LAYER_W + SLOT_W + COL_W + SHIFT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ITER_W-1:0]  max_iter,
  output logic [LAYER_W-1:0] tbl_layer,
  output logic [SLOT_W-1:0]  tbl_slot,
  input  logic [COL_W-1:0]   tbl_col,
  input  logic [SHIFT_W-1:0] tbl_shift,
  output logic               busy,
  output logic               done,
  output logic [ITER_W-1:0]  iter_idx,
  output logic               g_valid,
  output logic [LAYER_W-1:0] g_layer,
  output logic [SLOT_W-1:0]  g_slot,
  output logic [COL_W-1:0]   g_col,
  output logic [SHIFT_W-1:0] g_shift,
  output logic               g_pad,
  output logic               l_valid,
  output logic [LAYER_W-1:0] l_layer,
  output logic [SLOT_W-1:0]  l_slot,
  output logic [COL_W-1:0]   l_col,
  output logic [SHIFT_W-1:0] l_shift,
  output logic               l_wr_en
);

  localparam logic [COL_W-1:0] PAD_CODE = '1;

  logic               cnt_busy;
  logic [SLOT_W-1:0]  cnt_slot;
  logic [PHASE_W-1:0] cnt_phase;
  logic [SUP_W-1:0]   cnt_sup;

  lsched_counters #(
    .SLOTS  (SLOTS),
    .SUPER  (SUPER),
    .NSUPER (NSUPER),
    .ITER_W (ITER_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .max_iter (max_iter),
    .busy     (cnt_busy),
    .done     (done),
    .slot     (cnt_slot),
    .phase    (cnt_phase),
    .sup      (cnt_sup),
    .iter     (iter_idx)
  );

  // global stage: active in the first SUPER layer-times of each superlayer
  logic               glob_act;
  logic [LAYER_W-1:0] glob_layer;

  assign glob_act   = cnt_busy && (cnt_phase < PHASE_W'(SUPER));
  assign glob_layer = LAYER_W'(cnt_sup) * LAYER_W'(SUPER) + LAYER_W'(cnt_phase);

  assign busy      = cnt_busy;
  assign tbl_layer = glob_layer;
  assign tbl_slot  = cnt_slot;

  assign g_valid = glob_act;
  assign g_layer = glob_layer;
  assign g_slot  = cnt_slot;
  assign g_col   = tbl_col;
  assign g_shift = tbl_shift;
  assign g_pad   = glob_act && (tbl_col == PAD_CODE);

  // local stage: same fields one layer-time later
  logic [FLD_W-1:0] fld_in, fld_out;
  logic             dly_valid;

  assign fld_in = {glob_layer, cnt_slot, tbl_col, tbl_shift};

  lsched_delay #(
    .DW    (FLD_W),
    .DEPTH (SLOTS)
  ) u_dly (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (start),
    .in_valid  (glob_act),
    .in_data   (fld_in),
    .out_valid (dly_valid),
    .out_data  (fld_out)
  );

  assign l_valid = dly_valid;
  assign {l_layer, l_slot, l_col, l_shift} = fld_out;
  assign l_wr_en = dly_valid && (fld_out[SHIFT_W +: COL_W] != PAD_CODE);

  AST_LOCAL_TRAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (g_valid && l_valid) |-> ({1'b0, l_layer} + 1'b1 == {1'b0, g_layer})); // R3

  AST_NO_CROSS_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
    (g_valid && ((g_layer % LAYER_W'(SUPER)) == '0)) |-> !l_valid); // R4

  AST_SLOT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (g_valid && l_valid) |-> (g_slot == l_slot)); // R3

  AST_PAD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (l_valid && (l_col == PAD_CODE)) |-> !l_wr_en); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> (!g_valid && !l_wr_en)); // R1

endmodule

// File: tb/ldpc_layer_sched_tb.sv
module ldpc_layer_sched_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LAYERS = 12;
  localparam int SLOTS  = 8;
  localparam int SUPER  = 6;
  localparam int NSUP   = LAYERS / SUPER;
  localparam int PER_ITER = NSUP * (SUPER + 1) * SLOTS;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [3:0] max_iter;
  logic [3:0] tbl_layer;
  logic [2:0] tbl_slot;
  logic [4:0] tbl_col;
  logic [6:0] tbl_shift;
  logic       busy, done;
  logic [3:0] iter_idx;
  logic       g_valid, g_pad, l_valid, l_wr_en;
  logic [3:0] g_layer, l_layer;
  logic [2:0] g_slot, l_slot;
  logic [4:0] g_col, l_col;
  logic [6:0] g_shift, l_shift;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int tcol(input int l, input int s);
    if (s == SLOTS - 1 && (l % 6) != 5) return 31;
    return (l * 5 + s * 3) % 24;
  endfunction

  function automatic int tshift(input int l, input int s);
    return (l * 13 + s * 29 + 1) % 81;
  endfunction

  always_comb begin
    tbl_col   = 5'(tcol(int'(tbl_layer), int'(tbl_slot)));
    tbl_shift = 7'(tshift(int'(tbl_layer), int'(tbl_slot)));
  end

  ldpc_layer_sched dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .max_iter(max_iter),
    .tbl_layer(tbl_layer), .tbl_slot(tbl_slot), .tbl_col(tbl_col), .tbl_shift(tbl_shift),
    .busy(busy), .done(done), .iter_idx(iter_idx),
    .g_valid(g_valid), .g_layer(g_layer), .g_slot(g_slot), .g_col(g_col),
    .g_shift(g_shift), .g_pad(g_pad),
    .l_valid(l_valid), .l_layer(l_layer), .l_slot(l_slot), .l_col(l_col),
    .l_shift(l_shift), .l_wr_en(l_wr_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // compare all ports at offset c of a run with 'iters' iterations
  task automatic check_cycle(input int c, input int iters);
    int total, r, sp, ph, s, gl, ll;
    bit gv, lv;
    total = iters * PER_ITER;
    if (c >= total) begin
      chk("R7 busy after end", int'(busy), 0);
      chk("R7 done pulse", int'(done), (c == total) ? 1 : 0);
      chk("R7 g_valid idle", int'(g_valid), 0);
      chk("R7 l_valid idle", int'(l_valid), 0);
      return;
    end
    r  = c % PER_ITER;
    sp = r / ((SUPER + 1) * SLOTS);
    ph = (r / SLOTS) % (SUPER + 1);
    s  = c % SLOTS;
    gv = (ph < SUPER);
    lv = (ph >= 1);
    gl = sp * SUPER + ph;
    ll = sp * SUPER + ph - 1;
    chk("R6 busy", int'(busy), 1);
    chk("R7 done low while busy", int'(done), 0);
    chk("R6 iter_idx", int'(iter_idx), c / PER_ITER);
    chk("R4 g_valid", int'(g_valid), int'(gv));
    chk("R4 l_valid", int'(l_valid), int'(lv));
    if (gv) begin
      chk("R2 g_layer", int'(g_layer), gl);
      chk("R2 g_slot", int'(g_slot), s);
      chk("R2 tbl_layer", int'(tbl_layer), gl);
      chk("R2 g_col", int'(g_col), tcol(gl, s));
      chk("R2 g_shift", int'(g_shift), tshift(gl, s));
      chk("R5 g_pad", int'(g_pad), int'(tcol(gl, s) == 31));
    end else begin
      chk("R5 g_pad idle", int'(g_pad), 0);
    end
    if (lv) begin
      chk("R3 l_layer", int'(l_layer), ll);
      chk("R3 l_slot", int'(l_slot), s);
      chk("R3 l_col", int'(l_col), tcol(ll, s));
      chk("R3 l_shift", int'(l_shift), tshift(ll, s));
      chk("R5 l_wr_en", int'(l_wr_en), int'(tcol(ll, s) != 31));
    end else begin
      chk("R5 l_wr_en idle", int'(l_wr_en), 0);
    end
  endtask

  // launch a run and check cycles [0, stop_at]; stop_at < 0 means full run
  task automatic run(input int mi, input int stop_at, input bit poke_limit);
    int iters, last;
    iters = (mi == 0) ? 1 : mi;
    @(negedge clk);
    start = 1'b1;
    max_iter = 4'(mi);
    @(negedge clk);
    start = 1'b0;
    if (poke_limit) max_iter = 4'd15; // R9: ignored after start
    last = (stop_at < 0) ? iters * PER_ITER + 1 : stop_at;
    for (int c = 0; c <= last; c++) begin
      check_cycle(c, iters);
      if (c != last) @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    max_iter = 4'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 g_valid in reset", int'(g_valid), 0);
    chk("R1 l_valid in reset", int'(l_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy idle", int'(busy), 0);
    chk("R1 l_wr_en idle", int'(l_wr_en), 0);
    // R2 R3 R4 R5 R6 R7: two full iterations
    run(2, -1, 1'b0);
    // R6: limit 0 acts as one iteration
    run(0, -1, 1'b0);
    // R6 R9: one iteration, limit port changed after start
    run(1, -1, 1'b1);
    // R8: restart in the middle of a three-iteration run
    run(3, 70, 1'b0);
    run(1, -1, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule